// File: doc/BRIEF.md
# Drum Rotational Position Counter

This block follows the angular position of a spinning drum in units of word times. Each revolution of a track is split into a fixed number of sectors, and each sector is a gap of some length followed by a run of data words. A free-running counter advances by one physical word time on every `tick` and runs around the whole track. Only power-up reset clears it. A channel reset does not reach it, because the drum keeps turning.

The host can capture a position word with `rd_stb`, and the capture is taken only while the channel is idle. Inside a gap the captured value counts down: it is the data-word count minus the offset into the sector. Inside data it is the offset of the data word, with a data flag set just above the sector-and-word field. A latency calculator runs every clock. It takes a target drum address and returns the number of word times left until that address comes round, adding in the gaps of the sectors in front of it. The channel sequencer uses this number to schedule a transfer.

Top module: `drum_rot_pos`

## Requirements
- R1: After power-up reset, the rotational position starts at 0. It advances by exactly one physical word time on each clock with `tick` high and holds on clocks with `tick` low.
- R2: The position runs modulo one track of `2^SECT_BITS * (GAP_WORDS + 2^WORD_BITS)` word times. After the last word time of the last sector it returns to 0 (offset 0 of sector 0).
- R3: A capture with offset t into the current sector below `GAP_WORDS` (gap region) loads `pos_word = 2^WORD_BITS - t`, with the data flag clear.
- R4: A capture with t at or above `GAP_WORDS` (data region) loads `pos_word = (t - GAP_WORDS)` with the data flag at bit `WORD_BITS + SECT_BITS` set.
- R5: A capture requested while `busy` is high is ignored: `pos_word` keeps its previous value.
- R6: With `rd_stb` low, `pos_word` holds its value.
- R7: With target = `A + S * GAP_WORDS`, where A is the address bits `[WORD_BITS+SECT_BITS-1:0]` and S is the sector field `[WORD_BITS+SECT_BITS-1:WORD_BITS]`, the wait is target minus position. A result of zero or less has one track length added, so the wait always lies in 1..track length.
- R8: `wait_cnt` is registered. It appears one clock after `tgt_addr` is presented and uses the position as it stood in that same cycle, before any `tick` of that cycle.
- R9: Address bits above the sector field (the track number) have no effect on `wait_cnt`.
- R10: During power-up reset `pos_word` and `wait_cnt` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-up reset, active low |
| tick | input | 1 | One physical word time elapsed |
| rd_stb | input | 1 | Host request to capture the position word |
| busy | input | 1 | Channel busy; blocks the capture |
| tgt_addr | input | WORD_BITS+SECT_BITS+TRK_BITS | Target drum address (track, sector, word) |
| pos_word | output | WORD_BITS+SECT_BITS+1 | Captured position: gap countdown or flagged data offset |
| wait_cnt | output | clog2(track length + 1) | Word times until the target comes under the head |

## Verification
The bench builds the block with 4 sectors of 8 data words behind a 4-word gap, and with 2 track bits. That makes a 48-word track, so one revolution takes a few dozen ticks. Several full wraps, every gap and data offset, and the boundary at which the wait switches from a difference to a difference plus one track length all occur many times in a short run. The nonzero track bits in the random addresses show that the track number is ignored.

// File: rtl/drum_rot_pkg.sv
package drum_rot_pkg;

  // Position word for in-sector offset t: gap countdown or flagged data index.
  function automatic int unsigned enc_pos(input int unsigned t, input int unsigned gap,
                                          input int unsigned wbits, input int unsigned flagbit);
    if (t < gap) return (32'd1 << wbits) - t;
    return (t - gap) | (32'd1 << flagbit);
  endfunction

  // Word times until the target address comes round, always in 1..track.
  function automatic int unsigned rot_wait(input int unsigned addr, input int unsigned lin,
                                           input int unsigned wbits, input int unsigned sbits,
                                           input int unsigned gap, input int unsigned track);
    int unsigned sw;
    int unsigned tgt;
    sw  = addr & ((32'd1 << (wbits + sbits)) - 32'd1);
    tgt = sw + (sw >> wbits) * gap;
    if (tgt > lin) return tgt - lin;
    return tgt + track - lin;
  endfunction

endpackage

// File: rtl/drum_angle_ctr.sv
module drum_angle_ctr #(
  parameter int WORD_BITS = 11,
  parameter int SECT_BITS = 3,
  parameter int GAP_WORDS = 236,
  localparam int PHYS  = GAP_WORDS + (1 << WORD_BITS),
  localparam int TRACK = PHYS * (1 << SECT_BITS),
  localparam int OFFW  = $clog2(PHYS),
  localparam int LINW  = $clog2(TRACK)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  output logic [OFFW-1:0] off,
  output logic [LINW-1:0] lin
);
  logic [SECT_BITS-1:0] sec;
  logic                 sec_end;
  logic                 wrap_evt;

  assign sec_end  = (off == OFFW'(PHYS - 1));
  assign wrap_evt = tick && sec_end && (&sec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off <= '0;
      sec <= '0;
    end else if (tick) begin
      if (sec_end) begin
        off <= '0;
        sec <= sec + 1'b1;
      end else begin
        off <= off + 1'b1;
      end
    end
  end

  assign lin = LINW'(sec) * LINW'(PHYS) + LINW'(off);

  p_off_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    off < OFFW'(PHYS));
  p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !sec_end |=> off == $past(off) + 1'b1 && $stable(sec));
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(off) && $stable(sec));
  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> off == '0 && sec == '0);
endmodule

// File: rtl/drum_pos_word.sv
module drum_pos_word #(
  parameter int WORD_BITS = 11,
  parameter int SECT_BITS = 3,
  parameter int GAP_WORDS = 236,
  parameter int OFFW      = 12,
  localparam int FLAG = WORD_BITS + SECT_BITS,
  localparam int POSW = FLAG + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_stb,
  input  logic            busy,
  input  logic [OFFW-1:0] off,
  output logic [POSW-1:0] pos_word
);
  logic rd_take;
  logic in_gap;

  assign rd_take = rd_stb && !busy;
  assign in_gap  = off < OFFW'(GAP_WORDS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_word <= '0;
    else if (rd_take)
      pos_word <= POSW'(drum_rot_pkg::enc_pos(32'(off), GAP_WORDS, WORD_BITS, FLAG));
  end

  p_busy_ignore_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && busy |=> $stable(pos_word));
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(pos_word));
  p_gap_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_take && in_gap |=> !pos_word[FLAG] && pos_word <= POSW'(1 << WORD_BITS));
  p_data_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_take && !in_gap |=> pos_word[FLAG]);
endmodule

// File: rtl/drum_latency.sv
module drum_latency #(
  parameter int WORD_BITS = 11,
  parameter int SECT_BITS = 3,
  parameter int GAP_WORDS = 236,
  parameter int ADDRW     = 21,
  parameter int LINW      = 15,
  localparam int TRACK = (GAP_WORDS + (1 << WORD_BITS)) * (1 << SECT_BITS),
  localparam int WAITW = $clog2(TRACK + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ADDRW-1:0] tgt_addr,
  input  logic [LINW-1:0]  lin,
  output logic [WAITW-1:0] wait_cnt
);
  logic vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_cnt <= '0;
      vld      <= 1'b0;
    end else begin
      wait_cnt <= WAITW'(drum_rot_pkg::rot_wait(32'(tgt_addr), 32'(lin), WORD_BITS,
                                                SECT_BITS, GAP_WORDS, TRACK));
      vld      <= 1'b1;
    end
  end

  p_wait_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> wait_cnt != '0 && wait_cnt <= WAITW'(TRACK));
  p_wait_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vld && $stable(tgt_addr) && $stable(lin) |=> $stable(wait_cnt));
endmodule

// File: rtl/drum_rot_pos.sv
module drum_rot_pos #(
  parameter int WORD_BITS = 11,
  parameter int SECT_BITS = 3,
  parameter int TRK_BITS  = 7,
  parameter int GAP_WORDS = 236,
  localparam int ADDRW = WORD_BITS + SECT_BITS + TRK_BITS,
  localparam int POSW  = WORD_BITS + SECT_BITS + 1,
  localparam int PHYS  = GAP_WORDS + (1 << WORD_BITS),
  localparam int TRACK = PHYS * (1 << SECT_BITS),
  localparam int OFFW  = $clog2(PHYS),
  localparam int LINW  = $clog2(TRACK),
  localparam int WAITW = $clog2(TRACK + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             rd_stb,
  input  logic             busy,
  input  logic [ADDRW-1:0] tgt_addr,
  output logic [POSW-1:0]  pos_word,
  output logic [WAITW-1:0] wait_cnt
);
  logic [OFFW-1:0] off;
  logic [LINW-1:0] lin;

  drum_angle_ctr #(.WORD_BITS(WORD_BITS), .SECT_BITS(SECT_BITS), .GAP_WORDS(GAP_WORDS)) u_ctr (
    .clk(clk), .rst_n(rst_n), .tick(tick), .off(off), .lin(lin));

  drum_pos_word #(.WORD_BITS(WORD_BITS), .SECT_BITS(SECT_BITS), .GAP_WORDS(GAP_WORDS),
                  .OFFW(OFFW)) u_pos (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .busy(busy), .off(off), .pos_word(pos_word));

  drum_latency #(.WORD_BITS(WORD_BITS), .SECT_BITS(SECT_BITS), .GAP_WORDS(GAP_WORDS),
                 .ADDRW(ADDRW), .LINW(LINW)) u_lat (
    .clk(clk), .rst_n(rst_n), .tgt_addr(tgt_addr), .lin(lin), .wait_cnt(wait_cnt));
endmodule

// File: tb/tb_drum_rot_pos.sv
module tb_drum_rot_pos;
  localparam int WB = 3, SB = 2, TB = 2, GAP = 4;
  localparam int AW = WB + SB + TB;
  localparam int PW = WB + SB + 1;
  localparam int PHYS = GAP + (1 << WB);
  localparam int TRACK = PHYS * (1 << SB);
  localparam int WW = $clog2(TRACK + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, rd_stb = 1'b0, busy = 1'b0;
  logic [AW-1:0] tgt_addr = '0;
  logic [PW-1:0] pos_word;
  logic [WW-1:0] wait_cnt;

  int n_cmp = 0, n_bad = 0;
  int m_pos = 0, m_word = 0, m_wait = 0;
  string pos_tag = "R10", wait_tag = "R10";
  bit cmp_en = 1'b0;

  always #4 clk = ~clk;

  drum_rot_pos #(.WORD_BITS(WB), .SECT_BITS(SB), .TRK_BITS(TB), .GAP_WORDS(GAP)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rd_stb(rd_stb), .busy(busy),
    .tgt_addr(tgt_addr), .pos_word(pos_word), .wait_cnt(wait_cnt));

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference, updated at each rising edge from the inputs held since the falling edge.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_pos = 0; m_word = 0; m_wait = 0;
      pos_tag = "R10"; wait_tag = "R10";
    end else begin
      int t, a, tgt, d;
      t = m_pos % PHYS;
      if (rd_stb && !busy) begin
        if (t < GAP) begin m_word = 2 ** WB - t; pos_tag = "R3"; end
        else begin m_word = 2 ** (WB + SB) + (t - GAP); pos_tag = "R4"; end
      end else pos_tag = busy ? "R5" : "R6";
      a = int'(tgt_addr) % (2 ** (WB + SB));
      tgt = (a / (2 ** WB)) * PHYS + (a % (2 ** WB));
      d = tgt - m_pos;
      if (d <= 0) d = d + TRACK;
      m_wait = d;
      wait_tag = (int'(tgt_addr) >= 2 ** (WB + SB)) ? "R7 R8 R9" : "R7 R8";
      if (tick) begin
        m_pos = m_pos + 1;
        if (m_pos == TRACK) begin m_pos = 0; pos_tag = {pos_tag, " R1 R2"}; end
        else pos_tag = {pos_tag, " R1"};
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      check(pos_tag, int'(pos_word), m_word);
      check(wait_tag, int'(wait_cnt), m_wait);
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 pos_word", int'(pos_word), 0);
    check("R10 wait_cnt", int'(wait_cnt), 0);
    cmp_en = 1'b1;
    rst_n = 1'b1;
    // Sweep: tick and capture every cycle, address stepping over every value.
    for (int i = 0; i < 3 * TRACK + 5; i++) begin
      @(negedge clk);
      tick = 1'b1; rd_stb = 1'b1; busy = 1'b0;
      tgt_addr = AW'(i % (2 ** AW));
    end
    // Captures without ticks: position word must freeze (R1 hold).
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      tick = 1'b0; rd_stb = 1'b1; tgt_addr = AW'($urandom);
    end
    // Busy channel: captures ignored while ticking (R5).
    for (int i = 0; i < 3 * PHYS; i++) begin
      @(negedge clk);
      tick = 1'b1; rd_stb = 1'b1; busy = 1'b1; tgt_addr = AW'($urandom);
    end
    // Random mix of all inputs.
    for (int i = 0; i < 1500; i++) begin
      @(negedge clk);
      tick = 1'($urandom); rd_stb = 1'($urandom); busy = (($urandom % 4) == 0);
      tgt_addr = AW'($urandom);
    end
    @(negedge clk);
    tick = 1'b0; rd_stb = 1'b0; busy = 1'b0;
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #400000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule